// File: doc/BRIEF.md
# Averaged Virtual Sector Pulse Generator

This block lets a hard-sector floppy controller run from a disk that carries only an index hole. It times each revolution between rising edges of the index input, using a coarse tick derived from the system clock (500 ns at the default settings). It keeps a running average over a selectable number of recent revolutions and splits that average into equal sector intervals. It then emits one synthetic sector pulse per sector.

Each revolution's sequence is anchored on the index edge. The first pulse starts on the cycle the edge is detected. Each later pulse time is formed by adding the interval to the previous compare value, so rounding error never carries from one track pass into the next. Until enough revolutions have been seen to fill the chosen averaging depth, the output stays quiet and a not-ready flag is raised. A revolution that is more than twice as long as the current average is treated as a missed index and is kept out of the average.

Top module: `vsp_gen`

## Requirements
- R1: After reset, `sector_pulse` is low and `not_ready` is high.
- R2: A revolution period is the number of ticks between two consecutive rising edges of `index_in`, where one tick lasts `TICK_DIV` clock cycles. The first edge after reset only starts timing and yields no period.
- R3: `not_ready` stays high, and no pulse is produced, until as many periods as the selected depth have been accepted and the sector interval for them has been computed. `not_ready` then stays low until reset.
- R4: `cfg_depth_sel` value d selects an averaging depth of 2^d revolutions (0→1, 1→2, 2→4, 3→8). The average is the floor of the sum of the newest 2^d accepted periods divided by 2^d.
- R5: With depth select 0, the interval follows only the single most recent accepted period.
- R6: The interval I is floor(average / `cfg_sectors`), in ticks. Once ready, pulse k of a revolution (k = 0, 1, ...) rises k·I·`TICK_DIV` clock cycles after the cycle in which the index edge is detected. Pulse 0 rises in that same cycle.
- R7: At most `cfg_sectors` pulses are produced per revolution, after which the output stays idle. A new index edge abandons any pulses still due and restarts the sequence at pulse 0.
- R8: Each pulse stays high for `cfg_width` ticks (`cfg_width`·`TICK_DIV` cycles), provided `cfg_width` is at least 1 and below I.
- R9: Once the depth is full, a measured period greater than twice the current average is discarded. The average and interval stay unchanged, but pulses still restart at that index edge.
- R10: Sector counts of both 10 and 32 per track are supported (any value from 1 to 2^`SEC_W`−1). Configuration is held constant between resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| index_in | input | 1 | Index pulse from the drive, active high |
| cfg_depth_sel | input | DSEL_W | Averaging depth select, depth = 2^value |
| cfg_sectors | input | SEC_W | Sectors per track |
| cfg_width | input | WID_W | Pulse width in ticks |
| sector_pulse | output | 1 | Synthesized sector pulse |
| not_ready | output | 1 | High until the average is filled and an interval exists |

## Verification
The bench builds the block with `TICK_DIV` = 2, `PERIOD_W` = 16, `SEC_W` = 6, `WID_W` = 4 and `MAX_LOG` = 3. The two-cycle tick puts revolutions of several hundred ticks, and full fills of depths 1, 4 and 8, within a short run. The 16-bit period keeps the divider at 16 steps, so a fresh interval is in place before the second pulse of a 20-tick sector at 32 sectors. With these values the bench can exercise the discard threshold, early index restarts and averaging across uneven periods.

// File: rtl/vsp_pkg.sv
package vsp_pkg;

    // Divider control
    typedef enum logic {
        DIV_IDLE = 1'b0,
        DIV_RUN  = 1'b1
    } div_state_e;

    // Number of revolutions held for a given depth select
    function automatic int unsigned depth_of(input int unsigned sel);
        return 32'd1 << sel;
    endfunction

endpackage

// File: rtl/vsp_timebase.sv
module vsp_timebase #(
    parameter int TICK_DIV = 50,
    parameter int PERIOD_W = 20
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                index_in,
    output logic                idx_rise,
    output logic                tick,
    output logic [PERIOD_W-1:0] phase,
    output logic                per_vld,
    output logic [PERIOD_W-1:0] per_ticks
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PERIOD_W-1:0] PH_MAX = '1;
    localparam logic [PERIOD_W-1:0] PH_ONE = PERIOD_W'(1);

    logic [PRE_W-1:0] pre;
    logic             idx_q;
    logic             seen;

    // Prescaler is re-phased on every index edge so tick k lands k*TICK_DIV cycles later
    always_comb begin
        idx_rise = index_in && !idx_q;
        tick     = !idx_rise && (pre == PRE_W'(TICK_DIV - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q     <= 1'b0;
            pre       <= '0;
            seen      <= 1'b0;
            phase     <= '0;
            per_vld   <= 1'b0;
            per_ticks <= '0;
        end else begin
            idx_q   <= index_in;
            per_vld <= idx_rise && seen;
            if (idx_rise) begin
                seen      <= 1'b1;
                pre       <= '0;
                phase     <= '0;
                per_ticks <= (phase == PH_MAX) ? phase : phase + PH_ONE;
            end else begin
                pre <= tick ? '0 : pre + PRE_W'(1);
                if (tick && phase != PH_MAX) phase <= phase + PH_ONE;
            end
        end
    end

endmodule

// File: rtl/vsp_averager.sv
module vsp_averager #(
    parameter int PERIOD_W = 20,
    parameter int MAX_LOG  = 3,
    parameter int DSEL_W   = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [DSEL_W-1:0]   cfg_depth_sel,
    input  logic                per_vld,
    input  logic [PERIOD_W-1:0] per_ticks,
    output logic [PERIOD_W-1:0] avg,
    output logic                full,
    output logic                push
);
    localparam int MAX_DEPTH = 1 << MAX_LOG;
    localparam int SUM_W     = PERIOD_W + MAX_LOG;
    localparam int CNT_W     = MAX_LOG + 1;

    logic [PERIOD_W-1:0] hist [MAX_DEPTH];
    logic [SUM_W-1:0]    sum;
    logic [CNT_W-1:0]    fill;
    logic [CNT_W-1:0]    depth;
    logic [MAX_LOG-1:0]  oldest_idx;
    logic                too_long;
    logic                accept;

    always_comb begin
        depth      = CNT_W'(vsp_pkg::depth_of(int'(cfg_depth_sel)));
        oldest_idx = MAX_LOG'(depth - CNT_W'(1));
        full       = (fill == depth);
        avg        = PERIOD_W'(sum >> cfg_depth_sel);
        too_long   = full && ({1'b0, per_ticks} > {avg, 1'b0});
        accept     = per_vld && !too_long;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum  <= '0;
            fill <= '0;
            push <= 1'b0;
            for (int i = 0; i < MAX_DEPTH; i++) hist[i] <= '0;
        end else begin
            push <= accept;
            if (accept) begin
                sum <= sum + SUM_W'(per_ticks) - (full ? SUM_W'(hist[oldest_idx]) : '0);
                hist[0] <= per_ticks;
                for (int i = 1; i < MAX_DEPTH; i++) hist[i] <= hist[i-1];
                if (!full) fill <= fill + CNT_W'(1);
            end
        end
    end

    AST_FILL_WITHIN_DEPTH: assert property (@(posedge clk) disable iff (rst)
        fill <= depth);  // R3
    AST_LONG_PERIOD_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (per_vld && full && ({1'b0, per_ticks} > {avg, 1'b0})) |=> (!push && $stable(sum)));  // R9

endmodule

// File: rtl/vsp_divider.sv
module vsp_divider
    import vsp_pkg::*;
#(
    parameter int N_W = 20,
    parameter int D_W = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [N_W-1:0] dividend,
    input  logic [D_W-1:0] divisor,
    output logic [N_W-1:0] quo,
    output logic           done
);
    localparam int CNT_W = $clog2(N_W + 1);

    div_state_e     st;
    logic [CNT_W-1:0] cnt;
    logic [D_W-1:0] rem;
    logic [N_W-1:0] acc;
    logic [D_W:0]   trial;
    logic [D_W:0]   diff;
    logic           ge;

    // Restoring division, one quotient bit per cycle
    always_comb begin
        trial = {rem, acc[N_W-1]};
        ge    = trial >= {1'b0, divisor};
        diff  = trial - {1'b0, divisor};
        quo   = acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= DIV_IDLE;
            cnt  <= '0;
            rem  <= '0;
            acc  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                DIV_IDLE: if (start) begin
                    acc <= dividend;
                    rem <= '0;
                    cnt <= CNT_W'(N_W);
                    st  <= DIV_RUN;
                end
                DIV_RUN: begin
                    rem <= ge ? diff[D_W-1:0] : trial[D_W-1:0];
                    acc <= {acc[N_W-2:0], ge};
                    cnt <= cnt - CNT_W'(1);
                    if (cnt == CNT_W'(1)) begin
                        st   <= DIV_IDLE;
                        done <= 1'b1;
                    end
                end
                default: st <= DIV_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vsp_scheduler.sv
module vsp_scheduler #(
    parameter int PERIOD_W = 20,
    parameter int SEC_W    = 6,
    parameter int WID_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                ready,
    input  logic                idx_rise,
    input  logic                tick,
    input  logic [PERIOD_W-1:0] phase,
    input  logic [PERIOD_W-1:0] intv,
    input  logic                intv_load,
    input  logic [SEC_W-1:0]    cfg_sectors,
    input  logic [WID_W-1:0]    cfg_width,
    output logic                pulse
);
    localparam logic [PERIOD_W:0] CMP_ONE = (PERIOD_W+1)'(1);

    logic [PERIOD_W:0] cmp;
    logic [SEC_W-1:0]  sc;
    logic [WID_W-1:0]  wc;
    logic              active;
    logic              hit;

    always_comb begin
        active = (sc < cfg_sectors);
        hit    = tick && active && (({1'b0, phase} + CMP_ONE) == cmp);
        pulse  = (wc != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp <= '0;
            sc  <= '1;
            wc  <= '0;
        end else if (idx_rise) begin
            if (ready) begin
                cmp <= {1'b0, intv};
                sc  <= SEC_W'(1);
                wc  <= cfg_width;
            end else begin
                sc <= '1;
            end
        end else if (hit) begin
            cmp <= cmp + {1'b0, intv};
            sc  <= sc + SEC_W'(1);
            wc  <= cfg_width;
        end else begin
            // A freshly computed interval replaces the first compare if it is still pending
            if (intv_load && sc == SEC_W'(1)) cmp <= {1'b0, intv};
            if (tick && wc != '0) wc <= wc - WID_W'(1);
        end
    end

    AST_PULSE_STARTS_ON_GRID: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> ($past(idx_rise) || $past(tick)));  // R6
    AST_PULSE_ENDS_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse) |-> $past(tick));  // R8

endmodule

// File: rtl/vsp_gen.sv
module vsp_gen #(
    parameter int TICK_DIV = 50,
    parameter int PERIOD_W = 20,
    parameter int SEC_W    = 6,
    parameter int WID_W    = 8,
    parameter int MAX_LOG  = 3,
    localparam int DSEL_W  = (MAX_LOG > 0) ? $clog2(MAX_LOG + 1) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              index_in,
    input  logic [DSEL_W-1:0] cfg_depth_sel,
    input  logic [SEC_W-1:0]  cfg_sectors,
    input  logic [WID_W-1:0]  cfg_width,
    output logic              sector_pulse,
    output logic              not_ready
);
    localparam int PROD_W = PERIOD_W + SEC_W + 1;

    logic                idx_rise, tick, per_vld;
    logic [PERIOD_W-1:0] phase, per_ticks, avg, quo, intv;
    logic                full, push, div_done, ld_q, ready;

    vsp_timebase #(.TICK_DIV(TICK_DIV), .PERIOD_W(PERIOD_W)) u_time (
        .clk(clk), .rst(rst), .index_in(index_in), .idx_rise(idx_rise), .tick(tick),
        .phase(phase), .per_vld(per_vld), .per_ticks(per_ticks)
    );

    vsp_averager #(.PERIOD_W(PERIOD_W), .MAX_LOG(MAX_LOG), .DSEL_W(DSEL_W)) u_avg (
        .clk(clk), .rst(rst), .cfg_depth_sel(cfg_depth_sel), .per_vld(per_vld),
        .per_ticks(per_ticks), .avg(avg), .full(full), .push(push)
    );

    vsp_divider #(.N_W(PERIOD_W), .D_W(SEC_W)) u_div (
        .clk(clk), .rst(rst), .start(push), .dividend(avg), .divisor(cfg_sectors),
        .quo(quo), .done(div_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            intv  <= '0;
            ld_q  <= 1'b0;
            ready <= 1'b0;
        end else begin
            ld_q <= div_done;
            if (div_done) intv <= quo;
            if (div_done && full) ready <= 1'b1;
        end
    end

    vsp_scheduler #(.PERIOD_W(PERIOD_W), .SEC_W(SEC_W), .WID_W(WID_W)) u_sched (
        .clk(clk), .rst(rst), .ready(ready), .idx_rise(idx_rise), .tick(tick),
        .phase(phase), .intv(intv), .intv_load(ld_q), .cfg_sectors(cfg_sectors),
        .cfg_width(cfg_width), .pulse(sector_pulse)
    );

    assign not_ready = !ready;

    AST_QUIET_UNTIL_READY: assert property (@(posedge clk) disable iff (rst)
        not_ready |-> !sector_pulse);  // R3
    AST_INTERVAL_IS_QUOTIENT: assert property (@(posedge clk) disable iff (rst)
        (div_done && cfg_sectors != '0) |->
            ((PROD_W'(quo) * PROD_W'(cfg_sectors) <= PROD_W'(avg)) &&
             ((PROD_W'(quo) + PROD_W'(1)) * PROD_W'(cfg_sectors) > PROD_W'(avg))));  // R6

endmodule

// File: tb/tb_vsp_gen.sv
module tb_vsp_gen;
    localparam int TD = 2;
    localparam int PW = 16;
    localparam int SW = 6;
    localparam int WW = 4;
    localparam int ML = 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          index_in = 1'b0;
    logic [1:0]    dsel = '0;
    logic [SW-1:0] secs = SW'(10);
    logic [WW-1:0] wid = WW'(2);
    logic          sector_pulse, not_ready;

    vsp_gen #(.TICK_DIV(TD), .PERIOD_W(PW), .SEC_W(SW), .WID_W(WW), .MAX_LOG(ML)) dut (
        .clk(clk), .rst(rst), .index_in(index_in), .cfg_depth_sel(dsel),
        .cfg_sectors(secs), .cfg_width(wid), .sector_pulse(sector_pulse), .not_ready(not_ready)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Pulse monitor, sampled on the falling edge
    int   rise_t [64];
    int   width_c [64];
    int   nr = 0, nf = 0, start_t = 0;
    logic prev = 1'b0;
    always @(negedge clk) begin
        if (sector_pulse && !prev) begin
            if (nr < 64) rise_t[nr] = cyc;
            nr++;
            start_t = cyc;
        end
        if (!sector_pulse && prev) begin
            if (nf < 64) width_c[nf] = cyc - start_t;
            nf++;
        end
        prev = sector_pulse;
    end

    int checks = 0, fails = 0;
    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Reference model of the averaging state
    int hist [8];
    int fill, dep, have_prev, prev_len, mready;

    function automatic int mavg();
        int s = 0;
        for (int i = 0; i < dep; i++) s += hist[i];
        return s / dep;
    endfunction

    task automatic reset_dut(input int sel, input int s, input int w);
        rst = 1'b1; index_in = 1'b0;
        dsel = 2'(sel); secs = SW'(s); wid = WW'(w);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) hist[i] = 0;
        fill = 0; dep = 1 << sel; have_prev = 0; prev_len = 0; mready = 0;
        @(negedge clk);
    endtask

    // One revolution of p ticks starting with an index edge; checks its own pulses
    task automatic rev(input int p, input string req);
        int ready_now, per, s, iv, expn, t0;
        s = int'(secs);
        ready_now = mready;
        if (have_prev != 0) begin
            per = prev_len;
            if (!(fill == dep && per > 2 * mavg())) begin
                for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = per;
                if (fill < dep) fill++;
                if (fill == dep) mready = 1;
            end
        end
        have_prev = 1; prev_len = p;
        iv = mavg() / s;
        expn = 0;
        if (ready_now != 0)
            for (int k = 0; k < s; k++) if (k * iv < p) expn++;
        nr = 0; nf = 0;
        index_in = 1'b1;
        t0 = cyc + 1;
        repeat (3) @(negedge clk);
        index_in = 1'b0;
        repeat (p * TD - 3) @(negedge clk);
        chk(nr == expn, req, "pulse count", nr, expn);
        for (int k = 0; k < expn && k < nr; k++)
            chk(rise_t[k] - t0 == k * iv * TD, req, "pulse offset", rise_t[k] - t0, k * iv * TD);
        for (int k = 0; k < nf && k < 64; k++)
            chk(width_c[k] == int'(wid) * TD, "R8", "pulse width", width_c[k], int'(wid) * TD);
        chk(int'(not_ready) == (mready == 0 ? 1 : 0), "R3", "not_ready", int'(not_ready), (mready == 0 ? 1 : 0));
    endtask

    task automatic test_reset();
        reset_dut(2, 10, 2);
        chk(sector_pulse == 1'b0, "R1", "pulse after reset", int'(sector_pulse), 0);
        chk(not_ready == 1'b1, "R1", "not_ready after reset", int'(not_ready), 1);
    endtask

    task automatic test_fill_depth4();
        reset_dut(2, 10, 2);
        for (int i = 0; i < 5; i++) rev(400, "R3");
        rev(400, "R6");
        rev(400, "R10");
    endtask

    task automatic test_average();
        rev(360, "R4");
        rev(440, "R4");
        rev(480, "R4");
        rev(320, "R4");
        rev(400, "R4");
        rev(400, "R2");
    endtask

    task automatic test_restart();
        rev(200, "R7");
        rev(400, "R7");
        rev(400, "R7");
    endtask

    task automatic test_missing();
        rev(1300, "R9");
        rev(400, "R9");
        rev(400, "R9");
    endtask

    task automatic test_depth1();
        reset_dut(0, 32, 2);
        rev(640, "R5");
        rev(640, "R3");
        rev(640, "R10");
        rev(704, "R2");
        rev(704, "R5");
    endtask

    task automatic test_depth8();
        reset_dut(3, 10, 3);
        for (int i = 0; i < 9; i++) rev((i % 2 == 0) ? 380 : 420, "R3");
        rev(380, "R4");
        rev(420, "R4");
    endtask

    initial begin
        test_reset();
        test_fill_depth4();
        test_average();
        test_restart();
        test_missing();
        test_depth1();
        test_depth8();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule